// File: doc/BRIEF.md
# Trigger Source and Dwell Timer

This block produces the trigger for a latching multi-channel scaler. It combines three sources into one single-cycle pulse: a pin from outside, a periodic generator, and a command written over the register port. The pin and the periodic generator can each be turned off by a control bit. The command cannot be turned off. The periodic generator fires every N microseconds, where N is a 32-bit dwell value. The block derives microseconds from its system clock with a prescaler, so the clock rate is a parameter. The same microsecond base drives a free-running time tag that the event builder attaches to events. While the event builder reports that its buffer is full, no trigger leaves the block.

The 7-bit control word is written through three aliases. One loads the word directly. One sets the bits written as 1. One clears the bits written as 1. The bits that do not steer triggering are passed straight to the rest of the scaler: auto-reset, gate mode, time-tag enable and input standard. A board-reset command bit returns every register, counter and output to its reset value in one cycle.

The register port is a plain write strobe with address and data, plus a combinational read mux.

Word addresses:

| Address | Function |
|---|---|
| 0 | Control, direct load |
| 1 | Control, set bits |
| 2 | Control, clear bits |
| 3 | Dwell value |
| 4 | Command |
| 5 | Time tag (read only) |

Top module: `trig_source_top`

## Requirements
- R1: When control bit 0 is 1, each rising edge on `extTrig` gives exactly one `trigPulse`. The pulse is high in the third clock cycle after the edge is first sampled, however long the input stays high. When control bit 0 is 0, `extTrig` gives no pulse.
- R2: When control bit 1 is 1 and the dwell value N is not 0, `trigPulse` is high for one cycle every N×TICKS cycles. TICKS is the clock frequency divided by 1 MHz. The first pulse comes N×TICKS cycles after the write that started the timer.
- R3: A dwell value of 0 stops the periodic generator, even when control bit 1 is 1.
- R4: A write to address 4 with data bit 0 set makes `trigPulse` high in the next cycle, whatever the enable bits hold.
- R5: A write to address 0 loads control bits [6:0]. A write to address 1 ORs the written bits into the control word. A write to address 2 clears the bits written as 1. Reading addresses 0, 1 or 2 returns the control word in bits [6:0], with the upper bits 0.
- R6: The control bits drive these outputs: bit 2 drives `inputStdSel`, bit 3 drives `autoResetEn`, bits [5:4] drive `gateMode`, and bit 6 drives `timeTagEn`.
- R7: The time tag counts up by one every TICKS cycles, starting from 0 at the last reset. It is readable at address 5 and on `timeTag`.
- R8: A write to address 4 with data bit 4 set clears the control word, the dwell value, the time tag, both timers and `trigPulse`. A software trigger in the same write has no effect.
- R9: Triggers from several sources in the same cycle give one single-cycle pulse.
- R10: While `bufFull` is high, no `trigPulse` is produced.
- R11: The periodic timer starts again from zero whenever the dwell value is written or control bit 1 changes from 0 to 1.
- R12: After reset, the control word, the dwell value, the time tag and `trigPulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write word address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read word address |
| rdData | output | DATA_W | Read data (combinational) |
| extTrig | input | 1 | External trigger, asynchronous |
| bufFull | input | 1 | Event buffer full; blocks triggers |
| trigPulse | output | 1 | Merged trigger pulse |
| inputStdSel | output | 1 | Control bit 2 |
| autoResetEn | output | 1 | Counter auto-reset enable |
| gateMode | output | 2 | Gate input usage select |
| timeTagEn | output | 1 | Time tag enable for events |
| timeTag | output | DATA_W | Microsecond time tag |

## Verification
The bench sets CLK_HZ to 3 MHz, so TICKS is 3. With a microsecond only three cycles long, the bench can cover dwell values 1 to 4 for three full periods each. It can also compare the time tag against c/3 over twenty cycles after a board reset. The control word is only 7 bits wide, so the bench walks all 128 direct-load values. It then runs a sequence of computed set and clear masks against a model. Pulse widths of 1 to 4 cycles on the external input check the edge detection.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
  localparam int unsigned CTRL_W     = 7;
  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_SET      = 1;
  localparam int unsigned A_CLR      = 2;
  localparam int unsigned A_DWELL    = 3;
  localparam int unsigned A_CMD      = 4;
  localparam int unsigned A_TAG      = 5;
  localparam int unsigned CMD_SWTRIG = 0;
  localparam int unsigned CMD_BRST   = 4;
  localparam int unsigned EN_EXT     = 0;
  localparam int unsigned EN_PER     = 1;

  // control-to-datapath strobes, each valid for one cycle
  typedef struct packed {
    logic swTrig;
    logic restart;
    logic softRst;
  } trig_strobe_t;
endpackage

// File: rtl/us_prescaler.sv
`timescale 1ns/1ps
module us_prescaler #(
  parameter int unsigned TICKS = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PH_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  logic [PH_W-1:0] phase;

  assign tick = (phase == PH_W'(TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phase <= '0;
    else if (clr || tick) phase <= '0;
    else                  phase <= phase + 1'b1;
  end
endmodule

// File: rtl/trig_ctrl.sv
`timescale 1ns/1ps
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   timeTag,
  output logic [DATA_W-1:0]   rdData,
  output logic [CTRL_W-1:0]   ctrlReg,
  output logic [DATA_W-1:0]   dwellReg,
  output trig_strobe_t        strobe
);
  logic [CTRL_W-1:0] nextCtrl;
  logic cmdWr, dwellWr;

  assign cmdWr   = wrEn && (wrAddr == ADDR_W'(A_CMD));
  assign dwellWr = wrEn && (wrAddr == ADDR_W'(A_DWELL));

  always_comb begin
    nextCtrl = ctrlReg;
    if (wrEn) begin
      if (wrAddr == ADDR_W'(A_CTRL))     nextCtrl = wrData[CTRL_W-1:0];
      else if (wrAddr == ADDR_W'(A_SET)) nextCtrl = ctrlReg | wrData[CTRL_W-1:0];
      else if (wrAddr == ADDR_W'(A_CLR)) nextCtrl = ctrlReg & ~wrData[CTRL_W-1:0];
    end
  end

  assign strobe.softRst = cmdWr && wrData[CMD_BRST];
  assign strobe.swTrig  = cmdWr && wrData[CMD_SWTRIG] && !wrData[CMD_BRST];
  assign strobe.restart = dwellWr || (!ctrlReg[EN_PER] && nextCtrl[EN_PER]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      dwellReg <= '0;
    end else if (strobe.softRst) begin
      ctrlReg  <= '0;
      dwellReg <= '0;
    end else begin
      ctrlReg <= nextCtrl;
      if (dwellWr) dwellReg <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(A_CTRL) || rdAddr == ADDR_W'(A_SET) || rdAddr == ADDR_W'(A_CLR))
      rdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlReg};
    else if (rdAddr == ADDR_W'(A_DWELL))
      rdData = dwellReg;
    else if (rdAddr == ADDR_W'(A_TAG))
      rdData = timeTag;
  end
endmodule

// File: rtl/trig_dp.sv
`timescale 1ns/1ps
module trig_dp
  import trig_pkg::*;
#(
  parameter int unsigned TICKS  = 50,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  trig_strobe_t      strobe,
  input  logic              extEn,
  input  logic              perEn,
  input  logic [DATA_W-1:0] dwellReg,
  input  logic              extTrig,
  input  logic              bufFull,
  output logic              trigPulse,
  output logic [DATA_W-1:0] timeTag
);
  logic [2:0]        syncQ;
  logic              extEdge, running, perClr, perTick, tagTick, perFire;
  logic [DATA_W-1:0] perCnt;

  // two-stage synchroniser plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               syncQ <= '0;
    else if (strobe.softRst) syncQ <= '0;
    else                     syncQ <= {syncQ[1:0], extTrig};
  end
  assign extEdge = syncQ[1] && !syncQ[2];

  assign running = perEn && (dwellReg != '0);
  assign perClr  = strobe.softRst || strobe.restart || !running;

  us_prescaler #(.TICKS(TICKS)) perPresc (
    .clk(clk), .rstN(rstN), .clr(perClr), .tick(perTick));
  us_prescaler #(.TICKS(TICKS)) tagPresc (
    .clk(clk), .rstN(rstN), .clr(strobe.softRst), .tick(tagTick));

  assign perFire = running && perTick && (perCnt == dwellReg - DATA_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        perCnt <= '0;
    else if (perClr)  perCnt <= '0;
    else if (perTick) perCnt <= perFire ? '0 : perCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timeTag <= '0;
    else if (strobe.softRst) timeTag <= '0;
    else if (tagTick)        timeTag <= timeTag + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               trigPulse <= 1'b0;
    else if (strobe.softRst) trigPulse <= 1'b0;
    else trigPulse <= ((extEdge && extEn) || perFire || strobe.swTrig) && !bufFull;
  end
endmodule

// File: rtl/trig_source_top.sv
`timescale 1ns/1ps
module trig_source_top
  import trig_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              extTrig,
  input  logic              bufFull,
  output logic              trigPulse,
  output logic              inputStdSel,
  output logic              autoResetEn,
  output logic [1:0]        gateMode,
  output logic              timeTagEn,
  output logic [DATA_W-1:0] timeTag
);
  localparam int unsigned TICKS = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] dwellReg;
  trig_strobe_t      strobe;

  trig_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .timeTag(timeTag), .rdData(rdData),
    .ctrlReg(ctrlReg), .dwellReg(dwellReg), .strobe(strobe));

  trig_dp #(.TICKS(TICKS), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .extEn(ctrlReg[EN_EXT]), .perEn(ctrlReg[EN_PER]), .dwellReg(dwellReg),
    .extTrig(extTrig), .bufFull(bufFull), .trigPulse(trigPulse), .timeTag(timeTag));

  assign inputStdSel = ctrlReg[2];
  assign autoResetEn = ctrlReg[3];
  assign gateMode    = ctrlReg[5:4];
  assign timeTagEn   = ctrlReg[6];
endmodule

// File: rtl/trig_source_chk.sv
`timescale 1ns/1ps
module trig_source_chk
  import trig_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              bufFull,
  input logic              trigPulse,
  input logic [DATA_W-1:0] timeTag,
  input logic [CTRL_W-1:0] ctrlReg,
  input logic [DATA_W-1:0] dwellReg
);
  logic cmdWr;
  assign cmdWr = wrEn && (wrAddr == ADDR_W'(A_CMD));

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |=> !trigPulse); // R10
  AST_SW_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[CMD_SWTRIG] && !wrData[CMD_BRST] && !bufFull) |=> trigPulse); // R4
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(A_SET)) |=>
      ctrlReg == ($past(ctrlReg) | $past(wrData[CTRL_W-1:0]))); // R5
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(A_CLR)) |=>
      ctrlReg == ($past(ctrlReg) & ~$past(wrData[CTRL_W-1:0]))); // R5
  AST_ZERO_DWELL: assert property (@(posedge clk) disable iff (!rstN)
    (dwellReg == '0 && !ctrlReg[EN_EXT] && !(cmdWr && wrData[CMD_SWTRIG])) |=> !trigPulse); // R3
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdWr && wrData[CMD_BRST]) |=>
      (timeTag == $past(timeTag) || timeTag == $past(timeTag) + 1'b1)); // R7
  AST_BOARD_RST: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[CMD_BRST]) |=>
      (ctrlReg == '0 && dwellReg == '0 && timeTag == '0 && !trigPulse)); // R8
endmodule

bind trig_source_top trig_source_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .bufFull(bufFull), .trigPulse(trigPulse), .timeTag(timeTag),
  .ctrlReg(ctrlReg), .dwellReg(dwellReg));

// File: tb/tb_trig_source_top.sv
`timescale 1ns/1ps
module tb_trig_source_top;
  localparam int T = 3;
  logic clk = 0, rstN = 0, wrEn = 0, extTrig = 0, bufFull = 0;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0, rdData, timeTag;
  logic trigPulse, inputStdSel, autoResetEn, timeTagEn;
  logic [1:0] gateMode;
  int checks = 0, errors = 0;

  trig_source_top #(.CLK_HZ(3_000_000), .DATA_W(32), .ADDR_W(3)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extTrig(extTrig), .bufFull(bufFull),
    .trigPulse(trigPulse), .inputStdSel(inputStdSel), .autoResetEn(autoResetEn),
    .gateMode(gateMode), .timeTagEn(timeTagEn), .timeTag(timeTag));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic extPulse(input int w, input logic expectOne, input string req);
    int seen = 0;
    extTrig = 1;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (c == w) extTrig = 0;
      check(req, trigPulse, (expectOne && c == 3));
      seen += int'(trigPulse);
    end
    check(req, seen, expectOne ? 1 : 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [6:0] model, m;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12: reset state
    check("R12 pulse", trigPulse, 0);
    rd(0, v); check("R12 ctrl", v, 0);
    rd(3, v); check("R12 dwell", v, 0);
    rd(5, v); check("R12 tag", v, 0);
    check("R12 outs", {inputStdSel, autoResetEn, gateMode, timeTagEn}, 0);

    // R5 R6 direct load sweep; dwell is 0 so R3 holds throughout
    for (int i = 0; i < 128; i++) begin
      wr(0, {25'h1F0A5A5, 7'(i)});
      rd(0, v); check("R5 direct", v, i);
      check("R6 fields", {timeTagEn, gateMode, autoResetEn, inputStdSel},
            {i[6], i[5:4], i[3], i[2]});
      check("R3 no pulse", trigPulse, 0);
    end

    // R5 set and clear aliases against a model
    wr(0, 0); model = 0;
    for (int i = 0; i < 64; i++) begin
      m = 7'((i * 37 + 5) & 127);
      wr(1, {25'h0ABCDEF, m}); model = model | m;
      rd(1, v); check("R5 set", v, {25'd0, model});
      m = 7'((i * 91 + 3) & 127);
      wr(2, {25'h1234567, m}); model = model & ~m;
      rd(2, v); check("R5 clear", v, {25'd0, model});
    end

    // R4 software trigger with enables off
    wr(0, 0);
    wr(4, 1); check("R4 pulse", trigPulse, 1);
    @(negedge clk); check("R4 single", trigPulse, 0);

    // R10 buffer full blocks software trigger
    bufFull = 1;
    wr(4, 1); check("R10 sw blocked", trigPulse, 0);
    bufFull = 0;

    // R1 external trigger, widths 1..4, enabled and disabled
    wr(0, 1);
    for (int w = 1; w <= 4; w++) extPulse(w, 1, "R1 ext on");
    wr(0, 0);
    extPulse(2, 0, "R1 ext off");
    wr(0, 1); bufFull = 1;
    extPulse(2, 0, "R10 ext blocked");
    bufFull = 0;

    // R9 external and software trigger in the same cycle
    extTrig = 1;
    @(negedge clk); @(negedge clk);
    wr(4, 1); check("R9 merged", trigPulse, 1);
    extTrig = 0;
    @(negedge clk); check("R9 single", trigPulse, 0);
    @(negedge clk); check("R9 quiet", trigPulse, 0);

    // R2 periodic generator, dwell 1..4
    for (int n = 1; n <= 4; n++) begin
      wr(0, 0); wr(3, n); wr(1, 2);
      for (int c = 1; c <= 3 * n * T; c++) begin
        @(negedge clk); check("R2 period", trigPulse, (c % (n * T)) == 0);
      end
    end

    // R11 restart on dwell write while running
    repeat (5) @(negedge clk);
    wr(3, 2);
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk); check("R11 dwell wr", trigPulse, (c % 6) == 0);
    end
    // R11 restart on enable rise
    wr(2, 2); repeat (7) @(negedge clk);
    wr(1, 2);
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk); check("R11 enable", trigPulse, (c % 6) == 0);
    end

    // R3 zero dwell stops generator with enable still set
    wr(3, 0);
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk); check("R3 zero dwell", trigPulse, 0);
    end

    // R8 board reset, with software trigger in same write
    wr(0, 7'h7F); wr(3, 5);
    wr(4, 32'h11);
    check("R8 pulse", trigPulse, 0);
    rd(0, v); check("R8 ctrl", v, 0);
    rd(3, v); check("R8 dwell", v, 0);
    rd(5, v); check("R8 tag", v, 0);
    check("R8 outs", {inputStdSel, autoResetEn, gateMode, timeTagEn}, 0);
    // R7 time tag counts microseconds from the board reset
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      rd(5, v); check("R7 tag", v, c / T);
      check("R7 port", timeTag, c / T);
      check("R8 quiet", trigPulse, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule